// File: doc/BRIEF.md
# Timer-Paced DAC Waveform Player

This block is a small bus master that plays a stored periodic waveform into a byte-wide, address-mapped 12-bit DAC. After every reset it programs the converter once. It sends a control byte that selects the 2.048 V internal reference, pin-controlled output latching, normal power and fast settling. From then on an internal sample-rate timer paces the output. On each timer tick the block reads the next 12-bit sample from an on-chip 64-byte table. It writes the sample as two bytes, high byte first. It then pulses the load strobe so that the converter output changes in a single step.

Every minimum bus time is a nanosecond figure. The block turns each one into a whole number of clock cycles. It rounds up, and no phase is shorter than one cycle. A single state machine drives the bus. Its states are `ST_IDLE`, `ST_SETUP` (chip select low, write enable still high), `ST_STROBE` (write enable low), `ST_HOLD` (write enable high again, bus held) and `ST_LOAD` (load strobe low).

A slot register records what the current write carries: `SL_CFG`, `SL_HI` or `SL_LO`.

The transitions are:
- IDLE to SETUP/CFG when the configuration has not yet been written.
- IDLE to SETUP/HI on a tick or a pending tick.
- SETUP to STROBE, and STROBE to HOLD, when the dwell counter expires.
- HOLD/CFG to IDLE.
- HOLD/HI to SETUP/LO.
- HOLD/LO to LOAD.
- LOAD to IDLE, which also advances the table pointer.

A tick that arrives while a transaction is in flight is kept as pending. It starts the next transaction from the following IDLE cycle.

Top module: `dac_wave_player`

## Requirements
- R1: While `rst_n` is low, `dac_cs_n`, `dac_we_n` and `dac_load_n` are all high.
- R2: After each release of reset, the first write is exactly one configuration write of byte 0x11 to address 3. It comes before any sample write, and no load pulse goes with it. Address encoding: 3 is control, 1 is the sample high byte, 0 is the sample low byte.
- R3: Each sample transaction writes address 1, then address 0, then gives one load pulse. Address 2 is never presented while chip select is low.
- R4: The loaded code is {high byte bits 3:0, low byte}; the upper four bits of the high byte carry no meaning. Successive loads step through the table one sample at a time, and sample 31 is followed by sample 0. In the default table, sample k has the value 273·k for k < 16 and 273·(31−k) otherwise. Its high byte is table byte 2k and its low byte is table byte 2k+1.
- R5: Sample transactions are paced by a timer whose period is (256 − RELOAD) · TIMEBASE_NS ns. With the defaults this is 50 µs, so successive falling edges of the load strobe are exactly 50 µs apart.
- R6: Chip select falls at least 15 ns before write enable falls. Write enable is low only while chip select is low.
- R7: Data is stable at least 10 ns, and the address at least 20 ns, before write enable rises. Neither changes while write enable is low, and both are held at least 5 ns after it rises.
- R8: Write enable stays high at least 20 ns between two write pulses.
- R9: The load strobe falls at least 5 ns after the last rising edge of write enable and stays low at least 23 ns. It is low only while chip select and write enable are both high.
- R10: A tick that arrives during a transaction is not lost. Chip select of the next sample transaction falls one clock cycle after the load strobe returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; its period is the CLK_PERIOD_PS parameter |
| rst_n | input | 1 | Asynchronous active-low reset |
| dac_data | output | 8 | Byte bus to the converter |
| dac_addr | output | 2 | Register select: 3 control, 1 high byte, 0 low byte |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_we_n | output | 1 | Active-low write enable; data is taken on its rising edge |
| dac_load_n | output | 1 | Active-low load strobe that moves the held word to the output |

## Verification
The bench resets the block in the middle of the configuration write and at random points in sample playback. A design that does not restart cleanly would either skip the control byte or resume at the wrong table entry. A second instance runs with a timer period shorter than one transaction. A design that drops ticks while busy would leave idle gaps of several cycles between loads. A design that skips entries would break the stepping order. The bench plays more than 32 samples, so an off-by-one in the wrap would load a wrong code at sample 31 or at sample 0. A bus monitor measures every setup, hold and pulse width at nanosecond resolution. Any phase cut to zero cycles, or data moving while write enable is low, is reported.

// File: rtl/wave_pkg.sv
`timescale 1ns/1ps
package wave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_LOAD
    } phase_e;

    typedef enum logic [1:0] {
        SL_CFG,
        SL_HI,
        SL_LO
    } slot_e;

    localparam int unsigned DEF_SAMPLES = 32;

    // Nanosecond minimum to clock cycles, rounded up, never below one.
    function automatic int unsigned min_cycles(input int unsigned ns, input int unsigned clk_ps);
        int unsigned c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Default triangle: sample k -> 273 * level, high byte at 2k, low byte at 2k+1.
    function automatic logic [16*DEF_SAMPLES-1:0] triangle_table();
        logic [16*DEF_SAMPLES-1:0] t;
        t = '0;
        for (int k = 0; k < DEF_SAMPLES; k++) begin
            int unsigned lvl;
            logic [11:0] code;
            lvl  = (k < DEF_SAMPLES / 2) ? k : DEF_SAMPLES - 1 - k;
            code = 12'(lvl * 273);
            t[k*16 +: 8]     = {4'h0, code[11:8]};
            t[k*16 + 8 +: 8] = code[7:0];
        end
        return t;
    endfunction

endpackage

// File: rtl/wave_rate_timer.sv
`timescale 1ns/1ps
module wave_rate_timer #(
    parameter int unsigned PERIOD = 2500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned W = $clog2(PERIOD + 1);

    logic [W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(PERIOD - 1);
        end else if (tick) begin
            cnt_q <= W'(PERIOD - 1);
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wave_sample_rom.sv
`timescale 1ns/1ps
module wave_sample_rom #(
    parameter int unsigned NUM_BYTES = 64,
    parameter int unsigned IDX_W     = 6,
    parameter logic [8*NUM_BYTES-1:0] CONTENT = '0
) (
    input  logic [IDX_W-1:0] index,
    output logic [7:0]       byte_o
);
    assign byte_o = CONTENT[index*8 +: 8];
endmodule

// File: rtl/wave_dwell_counter.sv
`timescale 1ns/1ps
module wave_dwell_counter #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value;
        end else if (!expired) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/dac_wave_player.sv
`timescale 1ns/1ps
module dac_wave_player
    import wave_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 20000,
    parameter int unsigned TIMEBASE_NS   = 1000,
    parameter logic [7:0]  RELOAD        = 8'hCE,
    parameter logic [7:0]  CONFIG_WORD   = 8'h11,
    parameter int unsigned NUM_SAMPLES   = DEF_SAMPLES,
    parameter logic [16*NUM_SAMPLES-1:0] TABLE = triangle_table()
) (
    input  logic       clk,
    input  logic       rst_n,
    output logic [7:0] dac_data,
    output logic [1:0] dac_addr,
    output logic       dac_cs_n,
    output logic       dac_we_n,
    output logic       dac_load_n
);
    localparam int unsigned SAMPLE_CYCLES =
        (256 - int'(RELOAD)) * TIMEBASE_NS * 1000 / CLK_PERIOD_PS;
    localparam int unsigned D_SETUP  = min_cycles(15, CLK_PERIOD_PS);
    localparam int unsigned D_STROBE = max2(min_cycles(10, CLK_PERIOD_PS),
                                            min_cycles(20, CLK_PERIOD_PS));
    localparam int unsigned D_HOLD   = max2(min_cycles(5, CLK_PERIOD_PS),
                                            min_cycles(20, CLK_PERIOD_PS));
    localparam int unsigned D_LOAD   = min_cycles(23, CLK_PERIOD_PS);
    localparam int unsigned D_MAX    = max2(max2(D_SETUP, D_STROBE), max2(D_HOLD, D_LOAD));
    localparam int unsigned DW       = $clog2(D_MAX + 1);
    localparam int unsigned PTR_W    = $clog2(NUM_SAMPLES);
    localparam int unsigned BYTE_W   = PTR_W + 1;

    phase_e            phase_q, phase_d;
    slot_e             slot_q, slot_d;
    logic              cfg_done_q, pending_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              tick, expired, advance, start;
    logic [DW-1:0]     dwell_val;
    logic [7:0]        rom_byte;

    wave_rate_timer #(.PERIOD(SAMPLE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    wave_sample_rom #(
        .NUM_BYTES (2 * NUM_SAMPLES),
        .IDX_W     (BYTE_W),
        .CONTENT   (TABLE)
    ) u_rom (
        .index  ({ptr_q, (slot_q == SL_LO)}),
        .byte_o (rom_byte)
    );

    wave_dwell_counter #(.W(DW)) u_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (advance),
        .value   (dwell_val),
        .expired (expired)
    );

    assign start   = (phase_q == ST_IDLE) && cfg_done_q && (tick || pending_q);
    assign advance = (phase_d != phase_q) || (slot_d != slot_q);

    // Next-state logic
    always_comb begin
        phase_d = phase_q;
        slot_d  = slot_q;
        unique case (phase_q)
            ST_IDLE: begin
                if (!cfg_done_q) begin
                    phase_d = ST_SETUP;
                    slot_d  = SL_CFG;
                end else if (tick || pending_q) begin
                    phase_d = ST_SETUP;
                    slot_d  = SL_HI;
                end
            end
            ST_SETUP:  if (expired) phase_d = ST_STROBE;
            ST_STROBE: if (expired) phase_d = ST_HOLD;
            ST_HOLD: begin
                if (expired) begin
                    unique case (slot_q)
                        SL_CFG:  phase_d = ST_IDLE;
                        SL_HI: begin
                            phase_d = ST_SETUP;
                            slot_d  = SL_LO;
                        end
                        default: phase_d = ST_LOAD;
                    endcase
                end
            end
            ST_LOAD:   if (expired) phase_d = ST_IDLE;
            default:   phase_d = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (phase_d)
            ST_SETUP:  dwell_val = DW'(D_SETUP - 1);
            ST_STROBE: dwell_val = DW'(D_STROBE - 1);
            ST_HOLD:   dwell_val = DW'(D_HOLD - 1);
            ST_LOAD:   dwell_val = DW'(D_LOAD - 1);
            default:   dwell_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q    <= ST_IDLE;
            slot_q     <= SL_CFG;
            cfg_done_q <= 1'b0;
            pending_q  <= 1'b0;
            ptr_q      <= '0;
        end else begin
            phase_q <= phase_d;
            slot_q  <= slot_d;
            if (phase_q == ST_HOLD && slot_q == SL_CFG && expired) begin
                cfg_done_q <= 1'b1;
            end
            if (start) begin
                pending_q <= 1'b0;
            end else if (tick) begin
                pending_q <= 1'b1;
            end
            if (phase_q == ST_LOAD && expired) begin
                ptr_q <= (ptr_q == PTR_W'(NUM_SAMPLES - 1)) ? '0 : ptr_q + 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        dac_cs_n   = 1'b1;
        dac_we_n   = 1'b1;
        dac_load_n = 1'b1;
        unique case (phase_q)
            ST_SETUP:  dac_cs_n = 1'b0;
            ST_STROBE: begin
                dac_cs_n = 1'b0;
                dac_we_n = 1'b0;
            end
            ST_HOLD:   dac_cs_n = 1'b0;
            ST_LOAD:   dac_load_n = 1'b0;
            default: ;
        endcase
        unique case (slot_q)
            SL_CFG: begin
                dac_addr = 2'd3;
                dac_data = CONFIG_WORD;
            end
            SL_HI: begin
                dac_addr = 2'd1;
                dac_data = rom_byte;
            end
            default: begin
                dac_addr = 2'd0;
                dac_data = rom_byte;
            end
        endcase
    end
endmodule

// File: rtl/wave_player_checks.sv
`timescale 1ns/1ps
module wave_player_checks (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] data,
    input logic [1:0] addr,
    input logic       cs_n,
    input logic       we_n,
    input logic       load_n
);
    AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cs_n); // R6

    AST_CS_LEADS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(!cs_n)); // R6

    AST_BUS_STEADY_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(data) && $stable(addr))); // R7

    AST_BUS_HELD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> ($stable(data) && $stable(addr))); // R7

    AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |-> (cs_n && we_n)); // R9

    AST_LOAD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(load_n) |-> $past(we_n)); // R9

    AST_NO_RESERVED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (addr != 2'd2)); // R3
endmodule

bind dac_wave_player wave_player_checks u_checks (
    .clk    (clk),
    .rst_n  (rst_n),
    .data   (dac_data),
    .addr   (dac_addr),
    .cs_n   (dac_cs_n),
    .we_n   (dac_we_n),
    .load_n (dac_load_n)
);

// File: tb/dac_wave_player_test.sv
`timescale 1ns/1ps
module wave_bus_monitor #(
    parameter real PERIOD_NS  = 0.0,
    parameter real GAP_MAX_NS = 0.0
) (
    input  logic       rst_n,
    input  logic [7:0] data,
    input  logic [1:0] addr,
    input  logic       cs_n,
    input  logic       we_n,
    input  logic       load_n,
    output int         checks,
    output int         fails,
    output int         loads
);
    logic [7:0] p_data = 8'h00, hi = 8'h00, lo = 8'h00;
    logic [1:0] p_addr = 2'd0;
    logic       p_cs = 1'b1, p_we = 1'b1, p_ld = 1'b1;
    bit         expect_cfg = 1'b1, have_we = 1'b0, have_ldf = 1'b0, have_ldr = 1'b0;
    int         stage = 0, idx = 0;
    realtime    t_data = 0, t_addr = 0, t_cs = 0, t_we = 0, t_ldf = 0, t_ldr = 0;

    initial begin
        checks = 0;
        fails  = 0;
        loads  = 0;
    end

    function automatic int exp_code(input int k);
        return ((k < 16) ? k : 31 - k) * 273;
    endfunction

    function automatic longint ps(input realtime d);
        return longint'(d * 1000.0);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", req, what, $realtime, act, exp);
        end
    endtask

    always @(data or addr or cs_n or we_n or load_n or rst_n) begin
        realtime now;
        now = $realtime;
        if (!rst_n) begin
            expect_cfg = 1'b1;
            stage      = 0;
            idx        = 0;
            have_we    = 1'b0;
            have_ldf   = 1'b0;
            have_ldr   = 1'b0;
        end else begin
            if (data !== p_data) begin
                t_data = now;
                chk(we_n === 1'b1, "R7", "data moved with WE low", longint'(we_n), 1);
                if (have_we) chk(now - t_we >= 5.0, "R7", "data hold ps", ps(now - t_we), 5000);
            end
            if (addr !== p_addr) begin
                t_addr = now;
                chk(we_n === 1'b1, "R7", "addr moved with WE low", longint'(we_n), 1);
                if (have_we) chk(now - t_we >= 5.0, "R7", "addr hold ps", ps(now - t_we), 5000);
            end
            if (p_cs === 1'b1 && cs_n === 1'b0) begin
                t_cs = now;
                if (GAP_MAX_NS > 0.0 && have_ldr) begin
                    chk(now - t_ldr <= GAP_MAX_NS, "R10", "load-to-next-CS gap ps",
                        ps(now - t_ldr), ps(GAP_MAX_NS));
                    have_ldr = 1'b0;
                end
            end
            if (p_we === 1'b1 && we_n === 1'b0) begin
                chk(cs_n === 1'b0, "R6", "WE fell without CS", longint'(cs_n), 0);
                chk(now - t_cs >= 15.0, "R6", "CS-to-WE setup ps", ps(now - t_cs), 15000);
                if (have_we) chk(now - t_we >= 20.0, "R8", "WE high time ps", ps(now - t_we), 20000);
            end
            if (p_we === 1'b0 && we_n === 1'b1) begin
                chk(now - t_data >= 10.0, "R7", "data setup ps", ps(now - t_data), 10000);
                chk(now - t_addr >= 20.0, "R7", "addr setup ps", ps(now - t_addr), 20000);
                t_we    = now;
                have_we = 1'b1;
                if (expect_cfg) begin
                    chk(addr == 2'd3, "R2", "config address", longint'(addr), 3);
                    chk(data == 8'h11, "R2", "config byte", longint'(data), 17);
                    expect_cfg = 1'b0;
                end else if (addr == 2'd1) begin
                    chk(stage == 0, "R3", "high byte out of order", stage, 0);
                    hi    = data;
                    stage = 1;
                end else begin
                    chk(addr == 2'd0 && stage == 1, "R3", "low byte write address", longint'(addr), 0);
                    lo    = data;
                    stage = 2;
                end
            end
            if (p_ld === 1'b1 && load_n === 1'b0) begin
                chk(cs_n === 1'b1 && we_n === 1'b1, "R9", "load with bus active",
                    longint'({cs_n, we_n}), 3);
                chk(now - t_we >= 5.0, "R9", "WE-to-load setup ps", ps(now - t_we), 5000);
                chk(stage == 2 && !expect_cfg, "R3", "load before both bytes", stage, 2);
                chk({hi[3:0], lo} == 12'(exp_code(idx)), "R4", "loaded code",
                    longint'({hi[3:0], lo}), exp_code(idx));
                if (PERIOD_NS > 0.0 && have_ldf) begin
                    chk((now - t_ldf > PERIOD_NS - 0.001) && (now - t_ldf < PERIOD_NS + 0.001),
                        "R5", "load spacing ps", ps(now - t_ldf), ps(PERIOD_NS));
                end
                t_ldf    = now;
                have_ldf = 1'b1;
                idx      = (idx + 1) % 32;
                stage    = 0;
                loads++;
            end
            if (p_ld === 1'b0 && load_n === 1'b1) begin
                chk(now - t_ldf >= 23.0, "R9", "load low width ps", ps(now - t_ldf), 23000);
                t_ldr    = now;
                have_ldr = 1'b1;
            end
        end
        p_data = data;
        p_addr = addr;
        p_cs   = cs_n;
        p_we   = we_n;
        p_ld   = load_n;
    end
endmodule

module dac_wave_player_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_a_n = 1'b0, rst_b_n = 1'b0;
    logic [7:0] data_a, data_b;
    logic [1:0] addr_a, addr_b;
    logic       cs_a, we_a, ld_a, cs_b, we_b, ld_b;
    int         ck_a, fl_a, loads_a, ck_b, fl_b, loads_b;
    int         t_checks = 0, t_fails = 0;
    bit         timeout = 1'b0;

    dac_wave_player uut (
        .clk(clk), .rst_n(rst_a_n), .dac_data(data_a), .dac_addr(addr_a),
        .dac_cs_n(cs_a), .dac_we_n(we_a), .dac_load_n(ld_a)
    );

    // Timer period of 8 cycles, shorter than one 9-cycle transaction.
    dac_wave_player #(.TIMEBASE_NS(160), .RELOAD(8'hFF)) uut_fast (
        .clk(clk), .rst_n(rst_b_n), .dac_data(data_b), .dac_addr(addr_b),
        .dac_cs_n(cs_b), .dac_we_n(we_b), .dac_load_n(ld_b)
    );

    wave_bus_monitor #(.PERIOD_NS(50000.0), .GAP_MAX_NS(0.0)) mon_a (
        .rst_n(rst_a_n), .data(data_a), .addr(addr_a), .cs_n(cs_a), .we_n(we_a),
        .load_n(ld_a), .checks(ck_a), .fails(fl_a), .loads(loads_a)
    );

    wave_bus_monitor #(.PERIOD_NS(0.0), .GAP_MAX_NS(20.5)) mon_b (
        .rst_n(rst_b_n), .data(data_b), .addr(addr_b), .cs_n(cs_b), .we_n(we_b),
        .load_n(ld_b), .checks(ck_b), .fails(fl_b), .loads(loads_b)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        t_checks++;
        if (!ok) begin
            t_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        timeout = 1'b1;
    end

    initial begin
        void'($urandom(32'd20250));
        repeat (3) @(negedge clk);
        check({cs_a, we_a, ld_a} == 3'b111, "R1", "uut strobes in reset", longint'({cs_a, we_a, ld_a}), 7);
        check({cs_b, we_b, ld_b} == 3'b111, "R1", "uut_fast strobes in reset", longint'({cs_b, we_b, ld_b}), 7);
        rst_a_n = 1'b1;
        rst_b_n = 1'b1;
        // Directed: reset while the configuration write is under way (R2).
        repeat (2) @(negedge clk);
        rst_b_n = 1'b0;
        #1;
        check({cs_b, we_b, ld_b} == 3'b111, "R1", "strobes after mid-config reset", longint'({cs_b, we_b, ld_b}), 7);
        repeat (2) @(negedge clk);
        rst_b_n = 1'b1;
        // Random resets during playback.
        for (int i = 0; i < 3; i++) begin
            repeat ($urandom_range(400, 60)) @(negedge clk);
            rst_b_n = 1'b0;
            #1;
            check({cs_b, we_b, ld_b} == 3'b111, "R1", "strobes after random reset", longint'({cs_b, we_b, ld_b}), 7);
            repeat ($urandom_range(4, 1)) @(negedge clk);
            rst_b_n = 1'b1;
        end
        wait (loads_a >= 36 || timeout);
        @(negedge clk);
        check(!timeout, "R5", "watchdog expired before 36 loads", longint'(timeout), 0);
        check(loads_a >= 36, "R4", "samples played past the wrap", loads_a, 36);
        check(loads_b >= 1000, "R10", "back-to-back loads on fast timer", loads_b, 1000);
        $display("End of test - %0d assertions evaluated, %0d failures",
                 t_checks + ck_a + ck_b, t_fails + fl_a + fl_b);
        $finish;
    end
endmodule